// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block sits between a host register port and a three-wire serial EEPROM that holds 64 words of 16 bits. The host writes an 8-bit command word. The block turns that command into one serial transaction on chip select, serial clock, data-to-device and data-from-device. A busy flag stays set in the status word for the whole transaction, so software polls it before it issues the next command.

One data register serves both directions. Software loads it before it issues a write, and it holds the fetched word once a read has finished. The command word carries the word address in its low six bits and the operation code in bits 7:6. Code 2 reads, code 3 erases, and code 1 writes. Code 0 is a control frame, and the value 0x30 (address bits 5:4 set) unlocks the device for writing. After an erase or a write frame, the controller holds busy until the device raises its data line to signal that programming has completed.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: status, data register, chip select, serial clock and serial data out.
- R2: A command written while idle is accepted. On the next clock, status bit 15 (busy) is 1 and status bits 7:0 equal the command.
- R3: Each frame starts with a 1 bit. The opcode (command bits 7:6) follows, then the address (bits 5:0), both MSB first. Data out changes only while the serial clock is low, and the device samples it on the serial clock rising edge.
- R4: The serial clock toggles every CLK_HALF system clocks while a frame is in progress. It is low whenever chip select is low.
- R5: Opcode 2 (read) clocks in 16 data bits, MSB first, after the address. The bits are sampled at serial clock falling edges, and the word is in the data register before busy clears.
- R6: Opcode 1 (write) clocks out the data register contents, 16 bits MSB first, after the address.
- R7: After an erase (opcode 3) or write frame, busy stays 1 while the device holds its data line low. It clears 2*CLK_HALF+1 cycles after the line is seen high.
- R8: Opcode 0 frames, including the write-enable command 0x30, are 9 bits long with no ready wait. Busy lasts 20*CLK_HALF cycles.
- R9: Chip select is low for at least one full serial clock (2*CLK_HALF system clocks) between frames, and this gap lies inside busy. A read keeps busy high for exactly 52*CLK_HALF cycles.
- R10: A command written while busy is ignored. It starts no frame, and the status and data register are not changed by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_in | input | 8 | Command word: opcode in 7:6, address in 5:0 |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | DATA_W | Write data for the data register |
| status | output | 16 | Bit 15 busy, bits 7:0 last accepted command |
| data_out | output | DATA_W | Data register: loaded write data or fetched read word |
| ee_cs | output | 1 | Device chip select, active high |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data and ready signal from the device |

## Verification
Busy and the echoed command appear one clock after the strobe, and the bench reads status at the falling edge that follows. The busy interval is measured exactly for each command:
- A read takes 52*CLK_HALF cycles.
- A control frame takes 20*CLK_HALF cycles.
- A write the device refuses takes 52*CLK_HALF+1 cycles, and a refused erase takes 20*CLK_HALF+1.
- An accepted write or erase also includes the device programming time plus two cycles.

Read data and the frame bits the device model captured are compared only after busy has cleared. Serial clock high time, data stability while the clock is high, the chip-select gap, and busy during device programming are all watched on every falling edge.

// File: rtl/eeprom_ctl_pkg.sv
// Package: shared opcode, sequencer state and command types for the
// serial EEPROM command controller. Assumes a 6-bit word address.
package eeprom_ctl_pkg;
    localparam int ADDR_W = 6;
    localparam int OP_W   = 2;
    localparam int CMD_W  = OP_W + ADDR_W;

    typedef enum logic [OP_W-1:0] {
        OP_CTRL  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_ERASE = 2'd3
    } ee_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_READY,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        ee_op_e            op;
        logic [ADDR_W-1:0] addr;
    } ee_cmd_t;
endpackage

// File: rtl/eeprom_tick_gen.sv
// Module: serial clock phase tick generator. While run is high it pulses
// tick once every HALF system clocks. The first tick comes HALF clocks
// after run rises. Assumes HALF >= 1.
module eeprom_tick_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    // Count system clocks inside one serial half period; restart when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    generate
        if (HALF > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R4
        end
    endgenerate
endmodule

// File: rtl/eeprom_shift_seq.sv
// Module: frame sequencer. It drives chip select, serial clock and data out
// for one command frame. It shifts in read data and waits for the device
// ready level after erase and write. Each phase advances on a tick from the
// tick generator. Assumes start is only asserted while busy is low.
module eeprom_shift_seq
    import eeprom_ctl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  ee_cmd_t           cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ee_do,
    output logic              busy,
    output logic              run,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_word
);
    localparam int HDR_BITS   = 1 + OP_W + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int LW         = $clog2(FRAME_BITS + 1);

    seq_state_e            state;
    ee_op_e                op_q;
    logic [FRAME_BITS-1:0] tx;
    logic [DATA_W-1:0]     rx;
    logic [LW-1:0]         left;
    logic                  gap_ph;
    logic                  long_frame;

    assign long_frame = (cmd.op == OP_READ) || (cmd.op == OP_WRITE);

    // Step the frame: load on start, toggle the clock on ticks, shift bits, wait, gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_CTRL;
            tx      <= '0;
            rx      <= '0;
            left    <= '0;
            gap_ph  <= 1'b0;
            ee_cs   <= 1'b0;
            ee_sk   <= 1'b0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ee_cs <= 1'b1;
                        ee_sk <= 1'b0;
                        op_q  <= cmd.op;
                        tx    <= {1'b1, cmd.op, cmd.addr,
                                  (cmd.op == OP_WRITE) ? wdata : DATA_W'(0)};
                        left  <= long_frame ? LW'(FRAME_BITS) : LW'(HDR_BITS);
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!ee_sk) begin
                            ee_sk <= 1'b1;
                        end else begin
                            ee_sk <= 1'b0;
                            rx    <= {rx[DATA_W-2:0], ee_do};
                            if (left == LW'(1)) begin
                                ee_cs   <= 1'b0;
                                tx      <= '0;
                                rd_done <= (op_q == OP_READ);
                                state   <= (op_q == OP_WRITE || op_q == OP_ERASE)
                                           ? ST_READY : ST_GAP;
                            end else begin
                                tx   <= tx << 1;
                                left <= left - 1'b1;
                            end
                        end
                    end
                end
                ST_READY: begin
                    if (ee_do) begin
                        state <= ST_GAP;
                    end
                end
                default: begin
                    if (tick) begin
                        gap_ph <= ~gap_ph;
                        if (gap_ph) begin
                            state <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    assign ee_di   = tx[FRAME_BITS-1];
    assign busy    = (state != ST_IDLE);
    assign run     = (state == ST_SHIFT) || (state == ST_GAP);
    assign rd_word = rx;

    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs); // R4
    AST_DI_HELD_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> $stable(ee_di)); // R3
    AST_START_BIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> ee_di); // R3
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && !ee_do) |=> (state == ST_READY)); // R7
    AST_CS_LOW_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |=> !ee_cs); // R9
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
// Module: serial EEPROM command controller top. It holds the command and
// data registers, accepts commands only while idle, and loads the fetched
// word after a read. Assumes a device with 64 words of DATA_W bits that
// drives its data line high when ready.
module eeprom_cmd_ctrl
    import eeprom_ctl_pkg::*;
#(
    parameter int CLK_HALF = 4,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_in,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    output logic [15:0]       status,
    output logic [DATA_W-1:0] data_out,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int PAD_W = 15 - CMD_W;

    logic              busy;
    logic              run;
    logic              tick;
    logic              accept;
    logic              rd_done;
    logic [DATA_W-1:0] rd_word;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] data_q;

    assign accept = cmd_wr && !busy;

    // Capture the command word when a new transaction is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_in;
        end
    end

    // Data register: a finished read takes priority over a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_done) begin
            data_q <= rd_word;
        end else if (data_wr) begin
            data_q <= data_in;
        end
    end

    eeprom_tick_gen #(
        .HALF (CLK_HALF)
    ) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    eeprom_shift_seq #(
        .DATA_W (DATA_W)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (accept),
        .cmd     (ee_cmd_t'(cmd_in)),
        .wdata   (data_q),
        .ee_do   (ee_do),
        .busy    (busy),
        .run     (run),
        .ee_cs   (ee_cs),
        .ee_sk   (ee_sk),
        .ee_di   (ee_di),
        .rd_done (rd_done),
        .rd_word (rd_word)
    );

    assign status   = {busy, {PAD_W{1'b0}}, cmd_q};
    assign data_out = data_q;

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> busy); // R2
    AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> $stable(cmd_q)); // R10
    AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ee_cs); // R9
    AST_READ_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (data_q == $past(rd_word))); // R5
endmodule

// File: tb/test_eeprom_cmd_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_cmd_ctrl;
    localparam int HALF     = 4;
    localparam int DW       = 16;
    localparam int DEV_BUSY = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [7:0]    cmd_in = '0;
    logic          data_wr = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [15:0]   status;
    logic [DW-1:0] data_out;
    logic          ee_cs, ee_sk, ee_di;
    logic          m_do;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    eeprom_cmd_ctrl #(.CLK_HALF(HALF), .DATA_W(DW)) i_eeprom_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_in(cmd_in),
        .data_wr(data_wr), .data_in(data_in), .status(status),
        .data_out(data_out), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(m_do)
    );

    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 16'h1357) ^ 16'hA5C3;
    endfunction

    // ---------------- device model ----------------
    logic [15:0] mem [64];
    logic        wen, dev_prog, sk_q, last_start;
    int          nbits, prog_cnt, fr_cnt;
    logic [24:0] sh, m_s;
    int          m_n;
    logic [1:0]  cur_op, last_op;
    logic [5:0]  cur_addr, last_addr;
    logic [15:0] last_wdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
            wen <= 0; dev_prog <= 0; sk_q <= 0; nbits <= 0; prog_cnt <= 0;
            fr_cnt <= 0; m_do <= 1; sh <= '0; cur_op <= 0; cur_addr <= 0;
            last_start <= 0; last_op <= 0; last_addr <= 0; last_wdata <= 0;
        end else begin
            sk_q <= ee_sk;
            if (!ee_cs) begin
                nbits <= 0;
                if (!dev_prog) m_do <= 1;
            end else if (ee_sk && !sk_q) begin
                m_n = nbits + 1;
                m_s = {sh[23:0], ee_di};
                sh <= m_s;
                nbits <= m_n;
                if (m_n == 9) begin
                    fr_cnt <= fr_cnt + 1;
                    last_start <= m_s[8]; last_op <= m_s[7:6]; last_addr <= m_s[5:0];
                    cur_op <= m_s[7:6]; cur_addr <= m_s[5:0];
                    if (m_s[7:6] == 2'd0 && m_s[5:4] == 2'b11) wen <= 1;
                    if (m_s[7:6] == 2'd0 && m_s[5:4] == 2'b00) wen <= 0;
                    if (m_s[7:6] == 2'd3 && wen) begin
                        mem[m_s[5:0]] <= 16'hFFFF;
                        m_do <= 0; prog_cnt <= DEV_BUSY; dev_prog <= 1;
                    end
                end
                if (m_n >= 10 && m_n <= 25 && cur_op == 2'd2) m_do <= mem[cur_addr][25-m_n];
                if (m_n == 25 && cur_op == 2'd1) begin
                    last_wdata <= m_s[15:0];
                    if (wen) begin
                        mem[cur_addr] <= m_s[15:0];
                        m_do <= 0; prog_cnt <= DEV_BUSY; dev_prog <= 1;
                    end
                end
            end
            if (prog_cnt != 0) begin
                prog_cnt <= prog_cnt - 1;
                if (prog_cnt == 1) begin dev_prog <= 0; m_do <= 1; end
            end
        end
    end

    // ---------------- interface monitors ----------------
    int sk_run = 0, cs_low = 1000, sk_err = 0, di_err = 0, gap_err = 0, rdy_err = 0;
    logic p_sk = 0, p_cs = 0, p_di = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ee_sk) sk_run <= sk_run + 1;
            if (!ee_sk && p_sk) begin
                if (sk_run != HALF) sk_err <= sk_err + 1;
                sk_run <= 0;
            end
            if (ee_sk && p_sk && ee_di != p_di) di_err <= di_err + 1;
            if (ee_sk && !ee_cs) sk_err <= sk_err + 1;
            if (!ee_cs) cs_low <= cs_low + 1;
            if (ee_cs && !p_cs) begin
                if (cs_low < 2 * HALF) gap_err <= gap_err + 1;
                cs_low <= 0;
            end
            if (dev_prog && !status[15]) rdy_err <= rdy_err + 1;
            if (!ee_cs && status[15] == 1'b0 && ee_sk) sk_err <= sk_err + 1;
        end
        p_sk <= ee_sk; p_cs <= ee_cs; p_di <= ee_di;
    end

    // ---------------- reference and tasks ----------------
    logic [15:0] exp_mem [64];
    logic        exp_wen = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] c, output int bcyc);
        @(negedge clk); cmd_wr = 1; cmd_in = c;
        @(negedge clk); cmd_wr = 0;
        chk(status == {1'b1, 7'b0, c}, "R2 status after accept", status, {1'b1, 7'b0, c});
        bcyc = 1;
        while (status[15]) begin
            @(negedge clk);
            if (status[15]) bcyc++;
        end
    endtask

    task automatic check_frame(input logic [1:0] op, input logic [5:0] a);
        chk(last_start && last_op == op && last_addr == a, "R3 frame header",
            {last_start, last_op, last_addr}, {1'b1, op, a});
    endtask

    task automatic do_read(input logic [5:0] a);
        int b;
        issue({2'd2, a}, b);
        chk(b == 52 * HALF, "R9 read busy length", b, 52 * HALF);
        chk(data_out == exp_mem[a], "R5 read data", data_out, exp_mem[a]);
        check_frame(2'd2, a);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [15:0] d);
        int b;
        @(negedge clk); data_wr = 1; data_in = d;
        @(negedge clk); data_wr = 0;
        issue({2'd1, a}, b);
        chk(last_wdata == d, "R6 write data bits", last_wdata, d);
        check_frame(2'd1, a);
        if (exp_wen) begin
            exp_mem[a] = d;
            chk(b == 51 * HALF + DEV_BUSY + 2, "R7 write busy waits ready", b, 51 * HALF + DEV_BUSY + 2);
        end else begin
            chk(b == 52 * HALF + 1, "R7 refused write busy", b, 52 * HALF + 1);
        end
    endtask

    task automatic do_erase(input logic [5:0] a);
        int b;
        issue({2'd3, a}, b);
        check_frame(2'd3, a);
        if (exp_wen) begin
            exp_mem[a] = 16'hFFFF;
            chk(b == 19 * HALF + DEV_BUSY + 2, "R7 erase busy waits ready", b, 19 * HALF + DEV_BUSY + 2);
        end else begin
            chk(b == 20 * HALF + 1, "R7 refused erase busy", b, 20 * HALF + 1);
        end
    endtask

    task automatic do_ctrl(input logic [7:0] c);
        int b;
        issue(c, b);
        chk(b == 20 * HALF, "R8 control frame busy", b, 20 * HALF);
        check_frame(2'd0, c[5:0]);
        if (c[5:4] == 2'b11) exp_wen = 1;
        if (c[5:4] == 2'b00) exp_wen = 0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R2 watchdog: busy never settled actual=hung expected=done");
        summary();
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int fc;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 64; i++) exp_mem[i] = init_word(i);
        repeat (4) @(negedge clk);
        chk(status == 16'h0 && data_out == '0, "R1 reset registers", {status, data_out}, 0);
        chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1 reset pins", {ee_cs, ee_sk, ee_di}, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(status == 16'h0, "R1 idle after reset", status, 0);

        // refused program operations while write-locked
        do_write(6'd5, 16'h1234);
        do_read(6'd5);
        do_erase(6'd6);
        do_read(6'd6);

        // unlock, then boundary addresses and data patterns
        do_ctrl(8'h30);
        do_write(6'd0, 16'h0000);
        do_write(6'd63, 16'hFFFF);
        do_write(6'd62, 16'h8001);
        do_read(6'd0);
        do_read(6'd63);
        do_read(6'd62);
        do_erase(6'd0);
        do_read(6'd0);

        // constrained random mix
        for (int k = 0; k < 30; k++) begin
            logic [5:0] a;
            int r;
            a = 6'($urandom % 64);
            r = $urandom % 4;
            if (r == 1) do_write(a, 16'($urandom));
            else if (r == 2) do_erase(a);
            else do_read(a);
        end

        // command while busy must be ignored (R10)
        fc = fr_cnt;
        @(negedge clk); cmd_wr = 1; cmd_in = {2'd2, 6'd17};
        @(negedge clk); cmd_wr = 0;
        repeat (20) @(negedge clk);
        cmd_wr = 1; cmd_in = {2'd3, 6'd18};
        @(negedge clk); cmd_wr = 0;
        chk(status == {1'b1, 7'b0, 2'd2, 6'd17}, "R10 status kept while busy", status, {1'b1, 7'b0, 2'd2, 6'd17});
        while (status[15]) @(negedge clk);
        repeat (3 * HALF) @(negedge clk);
        chk(fr_cnt == fc + 1, "R10 single frame sent", fr_cnt, fc + 1);
        chk(status[7:0] == {2'd2, 6'd17}, "R10 status after ignored cmd", status[7:0], {2'd2, 6'd17});
        chk(data_out == exp_mem[17], "R10 read result intact", data_out, exp_mem[17]);
        do_read(6'd18);

        // relock and confirm writes are refused
        do_ctrl(8'h00);
        do_write(6'd10, 16'hBEEF);
        do_read(6'd10);

        chk(sk_err == 0, "R4 serial clock half period", sk_err, 0);
        chk(di_err == 0, "R3 data stable while clock high", di_err, 0);
        chk(gap_err == 0, "R9 chip select gap", gap_err, 0);
        chk(rdy_err == 0, "R7 busy during device programming", rdy_err, 0);

        summary();
        $finish;
    end
endmodule